// File: doc/BRIEF.md
# Grouped Timer Tick Generator

This block turns one base clock into five independent tick enables for a bank of timer channels. Two 8-bit prescalers form the first stage. The first prescaler serves a low group of channels and the second serves the remaining channels. Each prescaler divides the base clock by its programmed value plus one.

Each channel then reads a 4-bit selector code. A code that is not flagged as external divides the channel's prescaled tick further by a power of two. A code that is flagged in the external-code mask makes the channel follow an external tick input instead. That input is first synchronized into the base clock domain, and only its rising edges count. Every output is a single-cycle enable, intended to advance a downstream counter.

Two write-strobed configuration words set up the block. Word 0 holds both prescaler values. Word 1 holds the five selector codes. Writing word 0 restarts both prescalers and every channel divider. Writing word 1 restarts only the channel dividers. After either write, the timing of each output is set by the new values alone.

Top module: `tick_gen`

## Requirements
- R1: A prescaler programmed with value P emits one tick every P+1 base-clock cycles; P=255 gives 256 cycles.
- R2: Prescaler 0 is cfg0_wdata[7:0] and drives channels 0 and 1. Prescaler 1 is cfg0_wdata[15:8] and drives channels 2, 3 and 4.
- R3: The selector of channel n is cfg1_wdata[4n+3:4n]. A non-external code s gives an output period of (P+1)*2^(s+DIV_BASE) base cycles. The default DIV_BASE is 0, and the highest divide code by default is 14.
- R4: A selector code whose bit is set in EXT_MASK (by default only code 15) makes the channel ignore its prescaler. Channels 0 and 1 then follow ext_tick_in[0], and channels 2 to 4 follow ext_tick_in[1]. The other external input has no effect on such a channel.
- R5: A rising edge on an external input produces exactly one tick on each channel that follows it. The tick becomes visible after the third rising base-clock edge that samples the new level. A level held high produces no further ticks.
- R6: After a write to word 0, each divided channel's first tick is visible exactly one full period after the write edge. A write to word 1 restarts the channel dividers. With P=0, the first tick then comes 2^(s+DIV_BASE) cycles after that write.
- R7: When the period is longer than one cycle, every tick is high for exactly one base-clock cycle.
- R8: While reset is active, all ticks are low. After reset, both prescalers are 0 and all selectors are 0, so with DIV_BASE=0 every channel ticks on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg0_we | input | 1 | Write strobe for word 0 (prescalers) |
| cfg0_wdata | input | 16 | Prescaler 1 in [15:8], prescaler 0 in [7:0] |
| cfg1_we | input | 1 | Write strobe for word 1 (selectors) |
| cfg1_wdata | input | 20 | Selector of channel n in [4n+3:4n] |
| ext_tick_in | input | 2 | Asynchronous external tick sources |
| tick_o | output | 5 | One tick enable per channel |

## Verification
The bench targets the prescaler extremes of 0 and 255, and the largest divide code, where a counter one bit too narrow would wrap early and shorten the period. It measures the first-tick latency after each configuration write. A design that failed to clear its counters on a write would show a phase left over from the previous setting. Both channel groups are checked over the same window, which exposes a channel wired to the wrong prescaler. The external path is checked for a three-edge latency and for a single tick per rising edge. A level-sensitive design would fire on every cycle while the input is held high. A crossed input mapping would tick from the wrong source.

// File: rtl/tick_gen_pkg.sv
`timescale 1ns/1ps
package tick_gen_pkg;

  // Group that owns a channel: channels below the split use prescaler 0.
  function automatic int unsigned grp_of(int unsigned ch, int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

  // Terminal count of a power-of-two divider: 2^(code+base) - 1.
  function automatic int unsigned div_limit(int unsigned code, int unsigned base);
    return (32'd1 << (code + base)) - 32'd1;
  endfunction

endpackage

// File: rtl/tg_prescaler.sv
`timescale 1ns/1ps
module tg_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  assign tick = (cnt_q == div_val);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tg_ext_sync.sv
`timescale 1ns/1ps
module tg_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign pulse = sync_q & ~last_q;
endmodule

// File: rtl/tg_chan_div.sv
`timescale 1ns/1ps
module tg_chan_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic             ext_pulse,
  input  logic             use_ext,
  input  logic [CNT_W-1:0] limit,
  output logic             tick_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = pre_tick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (restart || use_ext) cnt_q <= '0;
      else if (pre_tick)      cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
      if (restart)      tick_q <= 1'b0;
      else if (use_ext) tick_q <= ext_pulse;
      else              tick_q <= hit;
    end
  end
endmodule

// File: rtl/tick_gen.sv
`timescale 1ns/1ps
module tick_gen #(
  parameter int NUM_CH    = 5,
  parameter int GRP_SPLIT = 2,
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 4,
  parameter int DIV_BASE  = 0,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h8000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg0_we,
  input  logic [2*PRE_W-1:0]      cfg0_wdata,
  input  logic                    cfg1_we,
  input  logic [NUM_CH*SEL_W-1:0] cfg1_wdata,
  input  logic [1:0]              ext_tick_in,
  output logic [NUM_CH-1:0]       tick_o
);
  import tick_gen_pkg::*;

  localparam int NUM_GRP = 2;
  localparam int CNT_W   = (1 << SEL_W);

  logic [NUM_GRP-1:0][PRE_W-1:0] pre_val;
  logic [NUM_CH*SEL_W-1:0]       sel_cfg;
  logic [NUM_GRP-1:0]            pre_tick;
  logic [NUM_GRP-1:0]            ext_pulse;
  logic [NUM_CH-1:0]             ext_sel;
  logic                          chan_restart;

  assign chan_restart = cfg0_we | cfg1_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_val <= '0;
      sel_cfg <= '0;
    end else begin
      if (cfg0_we) pre_val <= cfg0_wdata;
      if (cfg1_we) sel_cfg <= cfg1_wdata;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tg_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(cfg0_we),
      .div_val(pre_val[g]),
      .tick   (pre_tick[g])
    );
    tg_ext_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_tick_in[g]),
      .pulse   (ext_pulse[g])
    );
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int G = grp_of(i, GRP_SPLIT);
    logic [SEL_W-1:0] code;
    logic [CNT_W-1:0] limit;

    assign code       = sel_cfg[i*SEL_W +: SEL_W];
    assign ext_sel[i] = EXT_MASK[code];
    assign limit      = CNT_W'(div_limit(int'(code), DIV_BASE));

    tg_chan_div #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (chan_restart),
      .pre_tick (pre_tick[G]),
      .ext_pulse(ext_pulse[G]),
      .use_ext  (ext_sel[i]),
      .limit    (limit),
      .tick_q   (tick_o[i])
    );
  end
endmodule

// File: rtl/tick_gen_chk.sv
`timescale 1ns/1ps
module tick_gen_chk #(
  parameter int NUM_CH    = 5,
  parameter int GRP_SPLIT = 2,
  parameter int PRE_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg0_we,
  input logic [1:0][PRE_W-1:0]   pre_val,
  input logic [1:0]              pre_tick,
  input logic [1:0]              ext_pulse,
  input logic [NUM_CH-1:0]       ext_sel,
  input logic [NUM_CH-1:0]       tick_o
);
  import tick_gen_pkg::*;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick[g] && pre_val[g] != '0 && !cfg0_we |=> !pre_tick[g]); // R1
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cfg0_we |=> (pre_tick[g] == (pre_val[g] == '0))); // R6
    AST_EXT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pulse[g] |=> !ext_pulse[g]); // R5
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int G = grp_of(i, GRP_SPLIT);
    AST_DIV_FROM_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[i] && !$past(ext_sel[i]) |-> $past(pre_tick[G])); // R2
    AST_EXT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[i] && $past(ext_sel[i]) |-> $past(ext_pulse[G])); // R4
  end
endmodule

bind tick_gen tick_gen_chk #(
  .NUM_CH(NUM_CH), .GRP_SPLIT(GRP_SPLIT), .PRE_W(PRE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg0_we  (cfg0_we),
  .pre_val  (pre_val),
  .pre_tick (pre_tick),
  .ext_pulse(ext_pulse),
  .ext_sel  (ext_sel),
  .tick_o   (tick_o)
);

// File: tb/tick_gen_test.sv
`timescale 1ns/1ps
module tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg0_we = 1'b0;
  logic [15:0] cfg0_wdata = '0;
  logic        cfg1_we = 1'b0;
  logic [19:0] cfg1_wdata = '0;
  logic [1:0]  ext_tick_in = '0;
  logic [4:0]  tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tick_gen uut (
    .clk(clk), .rst_n(rst_n),
    .cfg0_we(cfg0_we), .cfg0_wdata(cfg0_wdata),
    .cfg1_we(cfg1_we), .cfg1_wdata(cfg1_wdata),
    .ext_tick_in(ext_tick_in), .tick_o(tick_o)
  );

  // {prescaler0, prescaler1, channel, selector code, expected period}
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{0,   0,   0, 0,  1},
    '{2,   0,   1, 1,  6},
    '{1,   4,   2, 0,  5},
    '{1,   4,   0, 2,  8},
    '{3,   1,   3, 3,  16},
    '{0,   7,   4, 2,  32},
    '{5,   0,   4, 4,  16},
    '{255, 0,   1, 0,  256},
    '{0,   255, 2, 1,  512},
    '{0,   0,   3, 14, 16384}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write0(input int p0, input int p1);
    @(negedge clk);
    cfg0_we = 1'b1;
    cfg0_wdata = {8'(p1), 8'(p0)};
    @(posedge clk);
    @(negedge clk);
    cfg0_we = 1'b0;
  endtask

  task automatic write1(input logic [19:0] w);
    @(negedge clk);
    cfg1_we = 1'b1;
    cfg1_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cfg1_we = 1'b0;
  endtask

  // Count rising edges until the channel shows a tick at the following negedge.
  task automatic count_to_tick(input int ch, input int cap, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!tick_o[ch] && n < cap);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int c0, c3, c2x;
    // R8: quiet during reset, then ticks on every cycle with default settings
    repeat (3) @(negedge clk);
    check(tick_o == 5'h00, "R8 reset low", int'(tick_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tick_o == 5'h1f, "R8 default every cycle", int'(tick_o), 31);

    // Vector table: latency after word-0 write, period, tick width
    for (int v = 0; v < NV; v++) begin
      int ch, expp;
      ch = VEC[v][2];
      expp = VEC[v][4];
      write1(20'(VEC[v][3]) << (4 * ch));
      write0(VEC[v][0], VEC[v][1]);
      count_to_tick(ch, expp + 4, n);
      check(n == expp, "R6 first tick after write", n, expp);
      count_to_tick(ch, expp + 4, n);
      check(n == expp, "R1 R2 R3 period", n, expp);
      if (expp > 1) begin
        @(posedge clk);
        @(negedge clk);
        check(tick_o[ch] == 1'b0, "R7 single-cycle tick", int'(tick_o[ch]), 0);
      end
    end

    // R2: both groups counted over one window
    write1(20'h0);
    write0(2, 6);
    c0 = 0; c3 = 0;
    for (int k = 0; k < 42; k++) begin
      @(posedge clk);
      @(negedge clk);
      c0 += int'(tick_o[0]);
      c3 += int'(tick_o[3]);
    end
    check(c0 == 14, "R2 group0 tick count", c0, 14);
    check(c3 == 6, "R2 group1 tick count", c3, 6);

    // R6: word-1 write alone restarts the channel divider
    write0(0, 0);
    repeat (5) @(negedge clk);
    write1(20'h00003);
    count_to_tick(0, 20, n);
    check(n == 8, "R6 restart on selector write", n, 8);

    // R4/R5: external source selection
    write1(20'h00F0F);
    write0(0, 0);
    c0 = 0; c2x = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      c0 += int'(tick_o[0]);
      c2x += int'(tick_o[2]);
    end
    check(c0 == 0 && c2x == 0, "R4 external idle", c0 + c2x, 0);
    check(tick_o[1] == 1'b1, "R4 non-external channel unaffected", int'(tick_o[1]), 1);

    ext_tick_in[0] = 1'b1;
    c2x = 0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      c2x += int'(tick_o[2]);
      if (k < 3) check(tick_o[0] == 1'b0, "R5 sync latency early", int'(tick_o[0]), 0);
      else       check(tick_o[0] == 1'b1, "R5 sync latency", int'(tick_o[0]), 1);
    end
    c0 = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      c0 += int'(tick_o[0]);
      c2x += int'(tick_o[2]);
    end
    check(c0 == 0, "R5 held level no retick", c0, 0);
    check(c2x == 0, "R4 other input ignored by channel 2", c2x, 0);

    ext_tick_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    ext_tick_in[1] = 1'b1;
    c0 = 0; c2x = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      c0 += int'(tick_o[0]);
      c2x += int'(tick_o[2]);
    end
    check(c2x == 1, "R4 channel 2 follows input 1", c2x, 1);
    check(c0 == 0, "R4 channel 0 ignores input 1", c0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule